// File: doc/BRIEF.md
# Up-counting compare timer

This block is an interval timer with a 32-bit counter that climbs by one on every clock while enabled and is compared with a programmable compare value. When the count matches the compare value, the timer raises a one-cycle interrupt pulse. After that match it does one of two things. It can return to zero and start a new period. Or it can stop and clear its own enable bit, so software sees through the control register that a one-shot period has finished.

Software reaches the timer through a plain synchronous register port. A bus decoder drives a write strobe, a two-bit word address and write data. Read data is the combinational view of the addressed register. Software can write the counter at any time, so a stopped timer can resume from any value. A new compare value applies from the next clock, whether or not the timer is running.

Top module: `ctimer`

## Requirements
- R1: The control register is at address 0. Bit 0 enables counting and bit 1 selects auto-restart. All 32 bits are stored and read back as written, and the other bits have no effect on counting.
- R2: While enabled and not at a hit, the counter at address 2 increases by exactly one per clock.
- R3: A hit is the enabled counter equal to the compare register at address 1. The interrupt output is high for the one cycle after the hit edge. The first pulse therefore appears compare − start + 1 cycles after the edge that wrote the enable bit.
- R4: With auto-restart clear, a hit leaves the counter at 0 and control bit 0 reads 0. No further counting and no further pulse follow.
- R5: With auto-restart set, a hit returns the counter to 0 and counting goes on. The next pulse follows compare + 1 cycles later.
- R6: A value written to the counter while stopped is kept. Setting the enable bit then counts from that value toward the compare value.
- R7: A compare write takes effect from the next clock while the timer runs, and moves the pending pulse accordingly.
- R8: Reset clears control, compare and counter to 0 and holds the interrupt low.
- R9: A counter write in the same cycle as an increment or a hit wins over the increment or the wrap. A hit in that cycle is still signalled.
- R10: Clearing the enable bit freezes the counter at its current value and produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; the counter steps on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Write strobe for the addressed register |
| reg_addr_i | input | 2 | Word address: 0 control, 1 compare, 2 counter, 3 unused (reads 0) |
| reg_wdata_i | input | W (32) | Write data |
| reg_rdata_o | output | W (32) | Combinational read data of the addressed register |
| irq_o | output | 1 | One-cycle interrupt pulse after a compare hit |

## Verification
A software counter write and a hardware event can fall on the same clock edge. The event is either an increment or the compare hit with its wrap to zero. The bench provokes this by placing the counter at the compare value and enabling the timer. It then writes a new counter value on exactly the next edge, which is the hit edge. It then checks three things: the interrupt pulse still appears, the counter reads the written value rather than zero, and the following pulse arrives after the number of cycles counted from the written value.

// File: rtl/ctimer_pkg.sv
package ctimer_pkg;
  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_CMP  = 2'd1,
    ADDR_CNT  = 2'd2,
    ADDR_NONE = 2'd3
  } ctimer_addr_e;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_AUTO_BIT = 1;
endpackage

// File: rtl/ctimer_regs.sv
module ctimer_regs
  import ctimer_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  ctimer_addr_e addr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         stop_i,
  output logic [W-1:0] ctrl_o,
  output logic [W-1:0] cmp_o,
  output logic         cnt_wr_o,
  output logic         cmp_wr_o
);
  logic [W-1:0] ctrl_q, cmp_q;
  logic         ctrl_wr;

  assign ctrl_wr  = wr_i && (addr_i == ADDR_CTRL);
  assign cmp_wr_o = wr_i && (addr_i == ADDR_CMP);
  assign cnt_wr_o = wr_i && (addr_i == ADDR_CNT);

  // software write wins over the hardware self-clear of the enable bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      cmp_q  <= '0;
    end else begin
      if (ctrl_wr)     ctrl_q <= wdata_i;
      else if (stop_i) ctrl_q[CTRL_EN_BIT] <= 1'b0;
      if (cmp_wr_o)    cmp_q <= wdata_i;
    end
  end

  assign ctrl_o = ctrl_q;
  assign cmp_o  = cmp_q;

  // R4: a one-shot hit clears the enable bit
  assert_self_stop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i && !ctrl_wr |=> !ctrl_q[CTRL_EN_BIT]);

  // R1: control holds its value unless written or self-cleared
  assert_ctrl_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_wr && !stop_i |=> $stable(ctrl_q));

  // R7: compare takes the written value on the next clock
  assert_cmp_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_wr_o |=> cmp_q == $past(wdata_i));
endmodule

// File: rtl/ctimer_core.sv
module ctimer_core #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         auto_i,
  input  logic [W-1:0] cmp_i,
  input  logic         cmp_wr_i,
  input  logic         cnt_wr_i,
  input  logic [W-1:0] cnt_wdata_i,
  output logic [W-1:0] cnt_o,
  output logic         hit_o,
  output logic         stop_o,
  output logic         irq_o
);
  logic [W-1:0] cnt_q;
  logic         irq_q;
  logic         hit_w;

  function automatic logic is_hit(logic en, logic [W-1:0] c, logic [W-1:0] m);
    return en && (c == m);
  endfunction

  function automatic logic [W-1:0] step(logic en, logic hit, logic [W-1:0] c);
    if (!en)     return c;
    else if (hit) return '0;
    else          return c + W'(1);
  endfunction

  assign hit_w  = is_hit(en_i, cnt_q, cmp_i);
  assign stop_o = hit_w && !auto_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= hit_w;
      if (cnt_wr_i) cnt_q <= cnt_wdata_i;
      else          cnt_q <= step(en_i, hit_w, cnt_q);
    end
  end

  assign cnt_o = cnt_q;
  assign hit_o = hit_w;
  assign irq_o = irq_q;

  assert_count_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !hit_w && !cnt_wr_i |=> cnt_q == $past(cnt_q) + W'(1));

  // R3: with a nonzero compare a hit cannot repeat on the next cycle
  assert_single_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_w && !cnt_wr_i && !cmp_wr_i && (cmp_i != '0) |=> !hit_w);

  assert_wrap_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_w && auto_i && !cnt_wr_i |=> cnt_q == '0);

  assert_load_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_wr_i |=> cnt_q == $past(cnt_wdata_i));

  assert_freeze_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i && !cnt_wr_i |=> $stable(cnt_q) && !irq_q);
endmodule

// File: rtl/ctimer.sv
module ctimer
  import ctimer_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         reg_wr_i,
  input  logic [1:0]   reg_addr_i,
  input  logic [W-1:0] reg_wdata_i,
  output logic [W-1:0] reg_rdata_o,
  output logic         irq_o
);
  ctimer_addr_e addr;
  logic [W-1:0] ctrl, cmp, cnt;
  logic         cnt_wr, cmp_wr, stop, hit;

  assign addr = ctimer_addr_e'(reg_addr_i);

  ctimer_regs #(.W(W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (reg_wr_i),
    .addr_i   (addr),
    .wdata_i  (reg_wdata_i),
    .stop_i   (stop),
    .ctrl_o   (ctrl),
    .cmp_o    (cmp),
    .cnt_wr_o (cnt_wr),
    .cmp_wr_o (cmp_wr)
  );

  ctimer_core #(.W(W)) u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (ctrl[CTRL_EN_BIT]),
    .auto_i      (ctrl[CTRL_AUTO_BIT]),
    .cmp_i       (cmp),
    .cmp_wr_i    (cmp_wr),
    .cnt_wr_i    (cnt_wr),
    .cnt_wdata_i (reg_wdata_i),
    .cnt_o       (cnt),
    .hit_o       (hit),
    .stop_o      (stop),
    .irq_o       (irq_o)
  );

  always_comb begin
    unique case (addr)
      ADDR_CTRL: reg_rdata_o = ctrl;
      ADDR_CMP:  reg_rdata_o = cmp;
      ADDR_CNT:  reg_rdata_o = cnt;
      default:   reg_rdata_o = '0;
    endcase
  end

  // R8: interrupt only follows a hit, so it stays low out of reset
  assert_irq_needs_hit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit |=> !irq_o);
endmodule

// File: tb/ctimer_bench.sv
module ctimer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;
  localparam int NV = 6;
  localparam int unsigned V_CMP  [NV] = '{3, 0, 7, 5, 20, 1};
  localparam int unsigned V_START[NV] = '{0, 0, 2, 5, 19, 0};
  localparam int unsigned V_AUTO [NV] = '{0, 0, 1, 0, 1, 1};

  logic clk = 0, rst_n = 0, wr = 0;
  logic [1:0] addr = 0;
  logic [W-1:0] wdata = 0, rdata;
  logic irq;
  int checks = 0, errors = 0;
  bit done = 0;

  ctimer #(.W(W)) u_ctimer (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [W-1:0] got, logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // called just after a negedge; returns just after the next negedge
  task automatic wr_reg(logic [1:0] a, logic [W-1:0] d);
    addr = a; wdata = d; wr = 1;
    @(negedge clk); #1;
    wr = 0;
  endtask

  task automatic rd_reg(logic [1:0] a, output logic [W-1:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic cycles_to_irq(output int n);
    n = 0;
    while (!irq && n < 5000) begin
      @(negedge clk); #1; n++;
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); #1; end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] v;
    int n;
    idle(3); rst_n = 1; idle(1);
    // R8 reset state
    rd_reg(0, v); check("R8 ctrl", v, 0);
    rd_reg(1, v); check("R8 cmp", v, 0);
    rd_reg(2, v); check("R8 cnt", v, 0);
    check("R8 irq", irq, 0);

    // vector table: first pulse timing, then the post-hit behaviour
    for (int i = 0; i < NV; i++) begin
      wr_reg(1, V_CMP[i]);
      wr_reg(2, V_START[i]);
      wr_reg(0, (V_AUTO[i] << 1) | 1);
      cycles_to_irq(n);
      check("R3 first pulse delay", n, V_CMP[i] - V_START[i] + 1);
      rd_reg(2, v); check("R4/R5 counter after hit", v, 0);
      if (V_AUTO[i] != 0) begin
        idle(1); check("R3 pulse width", irq, 0);
        cycles_to_irq(n);
        check("R5 restart period", n, V_CMP[i]);
        wr_reg(0, 0);
      end else begin
        rd_reg(0, v); check("R4 enable self-cleared", v, 0);
        idle(1); check("R3 pulse width", irq, 0);
        idle(3); rd_reg(2, v); check("R4 stays stopped", v, 0);
        check("R4 no second pulse", irq, 0);
      end
    end

    // R10 freeze and R2 stepping
    wr_reg(1, 1000); wr_reg(2, 0); wr_reg(0, 1);
    idle(5); wr_reg(0, 0);
    rd_reg(2, v); check("R2 count after six edges", v, 6);
    idle(10); rd_reg(2, v); check("R10 frozen counter", v, 6);
    check("R10 no pulse", irq, 0);

    // R6 resume from a written value
    wr_reg(2, 990); wr_reg(0, 1);
    cycles_to_irq(n); check("R6 resume delay", n, 11);

    // R7 compare change while running
    wr_reg(1, 1000); wr_reg(2, 0); wr_reg(0, 1);
    wr_reg(1, 10);
    cycles_to_irq(n); check("R7 new compare applied", n, 10);

    // R1 other control bits stored but inert
    wr_reg(2, 7); wr_reg(0, 32'hF0);
    idle(5); rd_reg(2, v); check("R1 no count with F0", v, 7);
    rd_reg(0, v); check("R1 ctrl readback", v, 32'hF0);
    wr_reg(0, 32'hF2); idle(4);
    rd_reg(2, v); check("R1 auto alone does not count", v, 7);

    // R9 counter write on the hit edge
    wr_reg(1, 5); wr_reg(2, 5); wr_reg(0, 3);
    wr_reg(2, 2);
    check("R9 hit still pulses", irq, 1);
    rd_reg(2, v); check("R9 written value wins over wrap", v, 2);
    idle(1);
    cycles_to_irq(n); check("R9 period from written value", n, 3);
    // R9 write wins over increment
    wr_reg(1, 1000); wr_reg(2, 40);
    rd_reg(2, v); check("R9 write over increment", v, 40);

    // R8 reset in the middle of a run
    rst_n = 0; idle(2);
    rd_reg(0, v); check("R8 ctrl after reset", v, 0);
    rd_reg(2, v); check("R8 cnt after reset", v, 0);
    rst_n = 1; idle(3);
    rd_reg(2, v); check("R8 stopped after reset", v, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule